// File: doc/BRIEF.md
# ROM Patch Address Match Unit

This block watches the instruction fetch address and compares it with two programmable patch addresses. Each comparator has its own enable bit. When an enabled comparator sees its address on a strobed fetch, the block sends a one-cycle branch request to the CPU, so that execution can move to replacement code. It also sets a sticky status flag for that comparator. Software reads the flag and clears it later.

Software reaches a control/status byte and the two patch address registers through a byte-wide register port. Every write carries a per-bit mask. A mask with a single bit set performs a single-bit write. A mask of all ones performs a full byte write. Each patch address takes `(AW+7)/8` consecutive byte locations, least significant byte first. The CPU redirection, the patch code and the ROM array sit outside this block.

Top module: `rom_patch_match`

## Requirements
- R1: After reset, every register location reads 0x00 and `patch_req` is low. This means both comparators are disabled, both status flags are clear and both patch addresses are zero.
- R2: A fetch with `fetch_valid` high and an address equal to an enabled comparator's patch address raises `patch_req` for exactly one cycle, in the cycle after the fetch. Without `fetch_valid`, no request is raised.
- R3: A comparator whose enable bit is 0 neither raises `patch_req` nor sets its status flag.
- R4: A status flag becomes 1 on a match of its enabled comparator. It stays 1 across any later fetches until software clears it.
- R5: Writing 0 to a status bit under its mask clears that flag. Writing 1 to a status bit leaves the flag unchanged.
- R6: At location 0, a write changes only the bits whose `reg_wmask` bit is 1. The layout is bit 3 = enable 1, bit 2 = status 1, bit 1 = enable 0 and bit 0 = status 0.
- R7: Bits 7 to 4 of location 0 always read 0, whatever was written to them.
- R8: If a match and a software clear of the same status flag happen in the same cycle, the flag ends up set.
- R9: When both comparators match on one fetch, `patch_sel` is 0, meaning comparator 0 wins, and both status flags are set. When only comparator 1 matches, `patch_sel` is 1.
- R10: Patch address k occupies locations `1+k*NB` through `k*NB+NB`, least significant byte first, and reads back what was written. Address bits at or above AW read 0. Locations beyond the last one read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch strobe |
| fetch_addr | input | AW | Instruction fetch address |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | RA_W | Register location (0 = control/status) |
| reg_wmask | input | 8 | Per-bit write mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| patch_req | output | 1 | One-cycle branch request |
| patch_sel | output | 1 | Comparator that caused the request |

## Verification
The bench builds the block with a 10-bit fetch address. Each patch address then spans two byte locations, and the partially used upper byte exercises the zero-fill of bits above the address width. With 10 bits, every fetch address can be swept under all four enable combinations, so every match, non-match and priority case is compared against arithmetic expectations. Directed sequences then cover the mask, clear-versus-set and dual-match corners.

// File: rtl/rom_patch_match.sv
module rom_patch_match #(
  parameter int AW = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   fetch_valid,
  input  logic [AW-1:0]                          fetch_addr,
  input  logic                                   reg_we,
  input  logic [$clog2(2*((AW+7)/8)+1)-1:0]      reg_addr,
  input  logic [7:0]                             reg_wmask,
  input  logic [7:0]                             reg_wdata,
  output logic [7:0]                             reg_rdata,
  output logic                                   patch_req,
  output logic                                   patch_sel
);
  localparam int NB   = (AW + 7) / 8;
  localparam int RA_W = $clog2(2 * NB + 1);

  logic [1:0]             en, st, hit;
  logic [1:0][AW-1:0]     car, car_nx;
  logic [1:0][NB*8-1:0]   car_pad;
  logic                   ctrl_wr;

  assign ctrl_wr = reg_we && (reg_addr == '0);

  for (genvar k = 0; k < 2; k++) begin : g_cmp
    assign hit[k] = fetch_valid && en[k] && (fetch_addr == car[k]);
  end

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      car_pad[k] = '0;
      car_pad[k][AW-1:0] = car[k];
    end
  end

  always_comb begin
    logic [NB*8-1:0] p;
    for (int k = 0; k < 2; k++) begin
      p = car_pad[k];
      for (int b = 0; b < NB; b++)
        if (reg_we && reg_addr == RA_W'(1 + k*NB + b))
          p[b*8 +: 8] = (p[b*8 +: 8] & ~reg_wmask) | (reg_wdata & reg_wmask);
      car_nx[k] = p[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= '0;
      st        <= '0;
      car       <= '0;
      patch_req <= 1'b0;
      patch_sel <= 1'b0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (ctrl_wr && reg_wmask[2*k+1]) en[k] <= reg_wdata[2*k+1];
        st[k] <= hit[k] | (st[k] & ~(ctrl_wr & reg_wmask[2*k] & ~reg_wdata[2*k]));
      end
      car       <= car_nx;
      patch_req <= |hit;
      patch_sel <= ~hit[0] & hit[1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = {4'b0, en[1], st[1], en[0], st[0]};
    for (int k = 0; k < 2; k++)
      for (int b = 0; b < NB; b++)
        if (reg_addr == RA_W'(1 + k*NB + b)) reg_rdata = car_pad[k][b*8 +: 8];
  end
endmodule

// File: rtl/rom_patch_match_chk.sv
module rom_patch_match_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_addr,
  input logic          patch_req,
  input logic          patch_sel,
  input logic          en0,
  input logic          en1,
  input logic          st0,
  input logic          st1,
  input logic [AW-1:0] car0,
  input logic [AW-1:0] car1
);
  logic m0, m1;
  assign m0 = fetch_valid && en0 && (fetch_addr == car0);
  assign m1 = fetch_valid && en1 && (fetch_addr == car1);

  AST_REQ_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    patch_req |-> $past(fetch_valid)); // R2
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    patch_req |-> $past(en0 || en1)); // R3
  AST_OFF_NO_SET0: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && !st0) |=> !st0); // R3
  AST_OFF_NO_SET1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en1 && !st1) |=> !st1); // R3
  AST_MATCH_SETS0: assert property (@(posedge clk) disable iff (!rst_n)
    m0 |=> (st0 && patch_req)); // R8
  AST_MATCH_SETS1: assert property (@(posedge clk) disable iff (!rst_n)
    m1 |=> (st1 && patch_req)); // R4
  AST_PRIO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    m0 |=> !patch_sel); // R9
  AST_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (m1 && !m0) |=> patch_sel); // R9
endmodule

bind rom_patch_match rom_patch_match_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .patch_req(patch_req), .patch_sel(patch_sel),
  .en0(en[0]), .en1(en[1]), .st0(st[0]), .st1(st[1]),
  .car0(car[0]), .car1(car[1])
);

// File: tb/tb_rom_patch_match.sv
module tb_rom_patch_match;
  localparam int AW = 10;
  localparam int NB = (AW + 7) / 8;
  localparam int RA_W = $clog2(2 * NB + 1);
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0, fetch_valid = 0, reg_we = 0;
  logic [AW-1:0] fetch_addr = '0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [7:0] reg_wmask = '0, reg_wdata = '0, reg_rdata;
  logic patch_req, patch_sel;
  int checks = 0, errors = 0;

  always #(TCLK/2) clk = ~clk;

  rom_patch_match #(.AW(AW)) dut (.*);

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(int a, int m, int d);
    reg_we = 1; reg_addr = RA_W'(a); reg_wmask = 8'(m); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 0; reg_wmask = '0;
  endtask

  task automatic rd(string r, int a, int exp);
    reg_addr = RA_W'(a); #1;
    chk(r, reg_rdata, exp);
  endtask

  task automatic fetch(int a);
    fetch_valid = 1; fetch_addr = AW'(a);
    @(negedge clk);
    fetch_valid = 0;
  endtask

  task automatic set_car(int k, int v);
    wr(1 + k*NB, 'hFF, v & 'hFF);
    wr(2 + k*NB, 'hFF, (v >> 8) & 'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, c1;
    c0 = 'h2A5; c1 = 'h15C;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 2*NB+1; a++) rd("R1", a, 0);
    chk("R1 req", patch_req, 0);
    // R10: address registers
    set_car(0, c0); set_car(1, c1);
    rd("R10", 1, 'hA5); rd("R10", 2, 'h02); rd("R10", 3, 'h5C); rd("R10", 4, 'h01);
    wr(2, 'hFF, 'hFF); rd("R10 upper", 2, 'h03);
    wr(2, 'hFF, 'h02); rd("R10", 2, 'h02);
    if (RA_W > 2) rd("R10 beyond", 2*NB+1, 0);
    // R3/R9/R2/R4: exhaustive sweep per enable mode
    for (int md = 0; md < 4; md++) begin
      int e0, e1;
      e0 = md & 1; e1 = (md >> 1) & 1;
      wr(0, 'hFF, (e1 << 3) | (e0 << 1));
      rd("R6", 0, (e1 << 3) | (e0 << 1));
      for (int a = 0; a < (1 << AW); a++) begin
        int h0, h1;
        h0 = (e0 != 0 && a == c0) ? 1 : 0;
        h1 = (e1 != 0 && a == c1) ? 1 : 0;
        fetch(a);
        chk(md == 0 ? "R3 req" : "R2 req", patch_req, h0 | h1);
        if (h0 | h1) chk("R9 sel", patch_sel, h0 ? 0 : 1);
      end
      rd("R4 status", 0, (e1 << 3) | (e1 << 2) | (e0 << 1) | e0);
    end
    // R2: one-cycle pulse and strobe needed
    wr(0, 'hFF, 'h0A);
    fetch(c0); chk("R2 pulse", patch_req, 1);
    @(negedge clk); chk("R2 pulse end", patch_req, 0);
    fetch_addr = AW'(c0); @(negedge clk); chk("R2 no strobe", patch_req, 0);
    // R5: write 1 ignored, write 0 clears
    wr(0, 'hFF, 'h0A); fetch(c0); fetch(c1); rd("R5 set", 0, 'h0F);
    wr(0, 'h05, 'h05); rd("R5 one ignored", 0, 'h0F);
    wr(0, 'h01, 'h00); rd("R5 clear0", 0, 'h0E);
    wr(0, 'h04, 'h00); rd("R5 clear1", 0, 'h0A);
    // R6: single-bit writes
    wr(0, 'h08, 'h00); rd("R6 bit", 0, 'h02);
    wr(0, 'h08, 'hFF); rd("R6 bit", 0, 'h0A);
    wr(0, 'h02, 'h00); rd("R6 bit", 0, 'h08);
    fetch(c0); chk("R6 en0 off", patch_req, 0);
    // R7: upper bits read zero
    wr(0, 'hFF, 'hF0); rd("R7", 0, 'h00);
    // R8: hardware set beats software clear
    wr(0, 'hFF, 'h02);
    fetch_valid = 1; fetch_addr = AW'(c0);
    reg_we = 1; reg_addr = '0; reg_wmask = 'h01; reg_wdata = 'h00;
    @(negedge clk);
    fetch_valid = 0; reg_we = 0;
    rd("R8", 0, 'h03);
    // R9: both match
    wr(0, 'hFF, 'h0A); set_car(1, c0);
    fetch(c0); chk("R9 req", patch_req, 1); chk("R9 sel", patch_sel, 0);
    rd("R9 both", 0, 'h0F);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule